// File: doc/BRIEF.md
# Sector Write-Protection Gate

This block sits between a flash command decoder and the program/erase engine. It decides whether each program or erase request may proceed. Every request carries a 20-bit byte address. Bits [19:12] name a 4 KB sector, and bits [19:16] name a 64 KB block. The highest block, sectors 0xF0 to 0xFF, is the top boot region.

Protection comes from two sources, combined by OR:

- **Software lock bits:** one lock bit per 64 KB block, held in sixteen registers that are written through a small register port.
- **Hardware pins:** two active-low protect pins.
  - The top-boot pin covers only the top boot region.
  - The general protect pin covers every other block.

Each pin can only force protection on. It never clears a lock. The register read-back always shows the software bit, even when a pin overrides it.

The gate samples the pins and the lock bits in the cycle a request is presented. One cycle later it gives exactly one verdict. A grant forwards the request's address and type downstream. A deny is a single-cycle pulse, and nothing is forwarded.

Top module: `sector_guard`

## Requirements
- R1: After reset, every lock bit reads 0 (unlocked) and neither `grantValid` nor `denyPulse` is high.
- R2: A request whose address bits [19:16] equal 0xF is denied whenever `topLockPinN` is 0 in the request cycle, whatever lock bit 15 holds.
- R3: A request to the top boot region while `topLockPinN` is 1 is denied when lock bit 15 is 1 and granted when it is 0.
- R4: A request whose address bits [19:16] are not 0xF is denied when `protPinN` is 0 or when the lock bit indexed by address bits [19:16] is 1, and granted otherwise.
- R5: `protPinN` has no effect on top boot region requests, and `topLockPinN` has no effect on requests to any other block.
- R6: When `regWrEn` is 1 at a clock edge, `regWrData` is stored into the lock bit selected by `regSel`. The new value shows on `lockBits[regSel]` after that edge, even while the pin covering that block is low.
- R7: Each request cycle produces exactly one of `grantValid` or `denyPulse`, high for the single following cycle. No verdict appears without a request. With a grant, `grantAddr` and `grantErase` equal the request's address and type (1 = erase, 0 = program).
- R8: The verdict uses only the pin levels and lock bits present in the request cycle. A pin change after that edge does not alter it, and a lock write at the same edge does not apply to that request.
- R9: Program and erase requests are protected identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqErase | input | 1 | Request type: 1 erase, 0 program |
| reqAddr | input | 20 | Target byte address |
| regWrEn | input | 1 | Lock register write strobe |
| regSel | input | 4 | Lock register (64 KB block) index |
| regWrData | input | 1 | Lock bit value to write (1 = locked) |
| topLockPinN | input | 1 | Active-low protect pin for the top boot region |
| protPinN | input | 1 | Active-low protect pin for all other blocks |
| grantValid | output | 1 | Request granted and forwarded |
| grantErase | output | 1 | Type of the forwarded request |
| grantAddr | output | 20 | Address of the forwarded request |
| denyPulse | output | 1 | One-cycle pulse for a denied request |
| lockBits | output | 16 | Read-back of all software lock bits |

## Verification
The following are checked on every cycle, whatever traffic is running:

- grant and deny are mutually exclusive;
- every request gets its verdict one cycle later, and no verdict appears without a request;
- a low pin forces a deny in its own region;
- top-region verdicts follow lock bit 15 while its pin is high;
- register writes land in the selected bit.

Some behaviours can only be shown by the bench's scenarios:

- a pin change just after the request edge leaves the verdict alone;
- a lock write at the request edge is ignored by that request;
- each pin leaves the other region untouched;
- a cleared lock bit reads back as cleared while its pin still forces protection.

// File: rtl/sector_guard_pkg.sv
`timescale 1ns/1ps
package sector_guard_pkg;

  // strobes sent from control to datapath
  typedef struct packed {
    logic capture;    // latch request and its verdict at this edge
    logic lockWrite;  // update one lock bit at this edge
  } guardStrobes_t;

endpackage

// File: rtl/sector_guard_dp.sv
`timescale 1ns/1ps
module sector_guard_dp
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  guardStrobes_t                 strb,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqErase,
  input  logic [ADDR_W-BLOCK_W-1:0]     regSel,
  input  logic                          regWrData,
  input  logic                          topLockPinN,
  input  logic                          protPinN,
  output logic                          blockedQ,
  output logic [ADDR_W-1:0]             addrQ,
  output logic                          eraseQ,
  output logic [(1<<(ADDR_W-BLOCK_W))-1:0] lockBits
);

  localparam int IDX_W   = ADDR_W - BLOCK_W;
  localparam int NUM_BLK = 1 << IDX_W;
  localparam int TOP_IDX = NUM_BLK - 1;

  logic [IDX_W-1:0]   reqIdx;
  logic               inTop;
  logic               pinForce;
  logic               blockNow;
  logic [NUM_BLK-1:0] lockQ;

  // region decode: the highest block is the top boot region
  assign reqIdx = reqAddr[ADDR_W-1 -: IDX_W];
  assign inTop  = (reqIdx == IDX_W'(TOP_IDX));

  // each pin only reaches its own region; a low pin forces protection
  always_comb begin
    if (inTop) pinForce = ~topLockPinN;
    else       pinForce = ~protPinN;
    blockNow = pinForce | lockQ[reqIdx];
  end

  // one software lock bit per block
  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : gLock
    always_ff @(posedge clk) begin
      if (!rstN)
        lockQ[gi] <= 1'b0;
      else if (strb.lockWrite && (regSel == IDX_W'(gi)))
        lockQ[gi] <= regWrData;
    end
  end

  // capture request with verdict taken from the request-cycle pins and locks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockedQ <= 1'b0;
      addrQ    <= '0;
      eraseQ   <= 1'b0;
    end else if (strb.capture) begin
      blockedQ <= blockNow;
      addrQ    <= reqAddr;
      eraseQ   <= reqErase;
    end
  end

  assign lockBits = lockQ;

endmodule

// File: rtl/sector_guard_ctl.sv
`timescale 1ns/1ps
module sector_guard_ctl
  import sector_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          regWrEn,
  input  logic          blockedQ,
  output guardStrobes_t strb,
  output logic          grantValid,
  output logic          denyPulse
);

  logic vldQ;

  always_comb begin
    strb.capture   = reqValid;
    strb.lockWrite = regWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) vldQ <= 1'b0;
    else       vldQ <= reqValid;
  end

  // exactly one verdict per captured request
  assign grantValid = vldQ & ~blockedQ;
  assign denyPulse  = vldQ &  blockedQ;

endmodule

// File: rtl/sector_guard.sv
`timescale 1ns/1ps
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              reqErase,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic                              regWrEn,
  input  logic [ADDR_W-BLOCK_W-1:0]         regSel,
  input  logic                              regWrData,
  input  logic                              topLockPinN,
  input  logic                              protPinN,
  output logic                              grantValid,
  output logic                              grantErase,
  output logic [ADDR_W-1:0]                 grantAddr,
  output logic                              denyPulse,
  output logic [(1<<(ADDR_W-BLOCK_W))-1:0]  lockBits
);

  guardStrobes_t strb;
  logic          blockedQ;

  sector_guard_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .regWrEn    (regWrEn),
    .blockedQ   (blockedQ),
    .strb       (strb),
    .grantValid (grantValid),
    .denyPulse  (denyPulse)
  );

  sector_guard_dp #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqErase    (reqErase),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .topLockPinN (topLockPinN),
    .protPinN    (protPinN),
    .blockedQ    (blockedQ),
    .addrQ       (grantAddr),
    .eraseQ      (grantErase),
    .lockBits    (lockBits)
  );

endmodule

// File: rtl/sector_guard_chk.sv
`timescale 1ns/1ps
module sector_guard_chk #(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              reqValid,
  input logic [ADDR_W-1:0]                 reqAddr,
  input logic                              regWrEn,
  input logic [ADDR_W-BLOCK_W-1:0]         regSel,
  input logic                              regWrData,
  input logic                              topLockPinN,
  input logic                              protPinN,
  input logic                              grantValid,
  input logic [ADDR_W-1:0]                 grantAddr,
  input logic                              denyPulse,
  input logic [(1<<(ADDR_W-BLOCK_W))-1:0]  lockBits
);

  localparam int IDX_W   = ADDR_W - BLOCK_W;
  localparam int TOP_IDX = (1 << IDX_W) - 1;

  logic reqTop;
  assign reqTop = (reqAddr[ADDR_W-1 -: IDX_W] == IDX_W'(TOP_IDX));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && denyPulse));

  a_r7_answer: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (grantValid || denyPulse));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(grantValid || denyPulse));

  a_r7_addr_fwd: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!grantValid || grantAddr == $past(reqAddr)));

  a_r2_top_pin: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTop && !topLockPinN) |=> denyPulse);

  a_r3_top_lock: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTop && topLockPinN) |=> (denyPulse == $past(lockBits[TOP_IDX])));

  a_r4_prot_pin: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqTop && !protPinN) |=> denyPulse);

  a_r6_lock_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (lockBits[$past(regSel)] == $past(regWrData)));

endmodule

bind sector_guard sector_guard_chk #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_chk (.*);

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;

  localparam int ADDR_W  = 20;
  localparam int BLOCK_W = 16;
  localparam int IDX_W   = ADDR_W - BLOCK_W;
  localparam int NB      = 1 << IDX_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN, reqValid, reqErase, regWrEn, regWrData;
  logic              topLockPinN, protPinN;
  logic [ADDR_W-1:0] reqAddr;
  logic [IDX_W-1:0]  regSel;
  logic              grantValid, grantErase, denyPulse;
  logic [ADDR_W-1:0] grantAddr;
  logic [NB-1:0]     lockBits;

  sector_guard u0 (.*);

  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] mdlLock;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expBlocked(input logic [ADDR_W-1:0] a, input bit topN, input bit wpN,
                                    input logic [NB-1:0] lk);
    int idx;
    idx = int'(a[ADDR_W-1 -: IDX_W]);
    if (idx == NB-1) return !topN || lk[idx];
    return !wpN || lk[idx];
  endfunction

  // called at a negedge; returns at the following negedge after checking
  task automatic step(input bit req, input logic [ADDR_W-1:0] a, input bit er,
                      input bit topN, input bit wpN,
                      input bit wr, input logic [IDX_W-1:0] sel, input bit dat,
                      input bit flip, input string tag);
    bit expB;
    reqValid = req; reqAddr = a; reqErase = er;
    topLockPinN = topN; protPinN = wpN;
    regWrEn = wr; regSel = sel; regWrData = dat;
    expB = expBlocked(a, topN, wpN, mdlLock);
    @(posedge clk);
    if (wr) mdlLock[sel] = dat;
    #1;
    if (flip) begin
      topLockPinN = ~topN; protPinN = ~wpN;
    end
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0;
    if (req) begin
      chk(grantValid == !expB, tag, {31'd0, grantValid}, {31'd0, !expB});
      chk(denyPulse == expB, tag, {31'd0, denyPulse}, {31'd0, expB});
      if (!expB) begin
        chk(grantAddr == a, "R7 addr", {12'd0, grantAddr}, {12'd0, a});
        chk(grantErase == er, "R9 type", {31'd0, grantErase}, {31'd0, er});
      end
    end else begin
      chk(!grantValid && !denyPulse, "R7 idle", {30'd0, grantValid, denyPulse}, 32'd0);
    end
    chk(lockBits == mdlLock, "R6 readback", {16'd0, lockBits}, {16'd0, mdlLock});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; reqValid = 1'b0; reqErase = 1'b0; reqAddr = '0;
    regWrEn = 1'b0; regSel = '0; regWrData = 1'b0;
    topLockPinN = 1'b1; protPinN = 1'b1;
    mdlLock = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lockBits == '0, "R1 locks", {16'd0, lockBits}, 32'd0);
    chk(!grantValid && !denyPulse, "R1 verdict", {30'd0, grantValid, denyPulse}, 32'd0);

    // R2 top pin low denies, program and erase (R9)
    step(1, 20'hF0000, 0, 0, 1, 0, 0, 0, 0, "R2 top pin program");
    step(1, 20'hFFFFF, 1, 0, 1, 0, 0, 0, 0, "R2 top pin erase R9");
    // R3 top pin high follows lock 15
    step(1, 20'hF8123, 0, 1, 1, 0, 0, 0, 0, "R3 top unlocked");
    step(0, 20'h0, 0, 1, 1, 1, 4'hF, 1, 0, "R6 set top");
    step(1, 20'hF8123, 1, 1, 1, 0, 0, 0, 0, "R3 top locked");
    // R8 same-edge write does not apply to this request
    step(1, 20'hF4000, 0, 1, 1, 1, 4'hF, 0, 0, "R8 same-edge write");
    step(1, 20'hF4000, 0, 1, 1, 0, 0, 0, 0, "R3 after unlock");
    // R4 other blocks
    step(1, 20'h3ABCD, 0, 1, 0, 0, 0, 0, 0, "R4 prot pin low");
    step(1, 20'h3ABCD, 1, 1, 1, 0, 0, 0, 0, "R4 unlocked grant");
    step(0, 20'h0, 0, 1, 1, 1, 4'h3, 1, 0, "R6 set 3");
    step(1, 20'h3ABCD, 0, 1, 1, 0, 0, 0, 0, "R4 lock 3");
    step(1, 20'hEFFFF, 0, 1, 1, 0, 0, 0, 0, "R4 block 14 grant");
    // R5 independence
    step(1, 20'hF1000, 1, 1, 0, 0, 0, 0, 0, "R5 prot pin vs top");
    step(1, 20'h00010, 1, 0, 1, 0, 0, 0, 0, "R5 top pin vs block 0");
    // R6 clear under low pin: reads 0, still denied (R2)
    step(0, 20'h0, 0, 0, 1, 1, 4'hF, 1, 0, "R6 set top again");
    step(0, 20'h0, 0, 0, 1, 1, 4'hF, 0, 0, "R6 clear under pin");
    chk(lockBits[NB-1] == 1'b0, "R6 cleared readback", {31'd0, lockBits[NB-1]}, 32'd0);
    step(1, 20'hF2222, 0, 0, 1, 0, 0, 0, 0, "R2 cleared still denied");
    // R8 pins change right after request edge
    step(1, 20'hF3333, 0, 1, 1, 0, 0, 0, 1, "R8 top pin drop late");
    step(1, 20'h53333, 0, 0, 0, 0, 0, 0, 1, "R8 prot pin rise late");
    step(1, 20'h53333, 1, 1, 1, 0, 0, 0, 1, "R8 prot pin drop late");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);
      if ($urandom_range(0, 3) == 0) a[ADDR_W-1 -: IDX_W] = '1;
      step($urandom_range(0, 3) != 0, a, 1'($urandom), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 3) != 0), $urandom_range(0, 2) == 0, IDX_W'($urandom),
           1'($urandom), 1'($urandom), "R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule